// File: doc/BRIEF.md
# Split Vertex/Texture Fetch Dispatcher

This block sits beside the math issue path of a shader core. It takes in fetch requests one at a time, each marked as a vertex fetch or a texture fetch and carrying a tag. It hands them to two execution units: one for vertex fetches and one for texture fetches. It can start up to two fetches in one cycle, at most one per unit. Math issue does not gate it. Each unit is modelled as a countdown of a configurable latency. A unit raises a completion pulse with the tag when that latency has run out, and it takes no new fetch until then.

A compile-time switch picks the queue organisation. In the split organisation, each fetch kind has its own small queue, so a slow vertex unit never holds back texture traffic. In the shared organisation, one queue of twice the depth holds both kinds in arrival order. Only its oldest two entries may start, so a blocked head stalls everything behind it. A counter of cycles in which work is outstanding lets the two organisations be compared under different latency mixes. The per-kind queue depth must be a power of two.

Top module: `fetch_split_dispatch`

## Requirements
- R1: Coming out of reset, `reqReady` is 1 for both kinds, no issue or completion pulse is active, and `busyCycles` is 0.
- R2: A request is taken on a rising edge where `reqValid` and `reqReady` are both 1. It can issue no earlier than the cycle after that edge, and it issues in exactly that cycle when its unit is free and nothing is queued ahead of it.
- R3: Split organisation (`DEDICATED`=1): vertex and texture requests each have a queue of `QDEPTH` entries. `reqReady`, looked at with `reqIsTex` set to the kind, is 0 exactly when that kind's queue is full. The other kind's fill level has no effect on it.
- R4: Shared organisation (`DEDICATED`=0): a single queue of 2×`QDEPTH` entries holds both kinds. When it is full, `reqReady` is 0 for both values of `reqIsTex`, even if the texture unit is idle.
- R5: Within each kind, requests issue in the order they were taken (`reqIsTex`=0 means vertex, 1 means texture).
- R6: In one cycle at most one vertex and one texture fetch start. In the split organisation, each queue head starts as soon as its own unit is free, with no regard to the other queue.
- R7: In the shared organisation only the oldest entry and the one behind it can start. The second one starts only if the oldest starts in the same cycle, is of the other kind, and its own unit is free. A head waiting on a busy unit therefore blocks a younger request of the other kind.
- R8: A unit is not pipelined. After an issue, its next issue comes no earlier than the cycle of its completion pulse. An issue in that same cycle is allowed.
- R9: A vertex fetch started in cycle c pulses `vtxDone` in cycle c+`VLAT`, and a texture fetch pulses `texDone` in cycle c+`TLAT`. The done tag equals the issued tag.
- R10: `busyCycles` goes up by one for every cycle in which a request is queued or a unit is busy, and it saturates at its maximum value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqIsTex | input | 1 | Request kind: 0 vertex, 1 texture |
| reqTag | input | TAG_W | Request tag |
| reqReady | output | 1 | Queue for the presented kind has space |
| vtxIssue | output | 1 | Vertex fetch starts this cycle |
| vtxIssueTag | output | TAG_W | Tag of the starting vertex fetch |
| texIssue | output | 1 | Texture fetch starts this cycle |
| texIssueTag | output | TAG_W | Tag of the starting texture fetch |
| vtxDone | output | 1 | Vertex unit completion pulse |
| vtxDoneTag | output | TAG_W | Tag of the completing vertex fetch |
| texDone | output | 1 | Texture unit completion pulse |
| texDoneTag | output | TAG_W | Tag of the completing texture fetch |
| busyCycles | output | CNT_W | Saturating count of cycles with outstanding work |

## Verification
Some properties are checked on every cycle. Each unit has at most one fetch in flight. Every completion arrives after exactly its unit's latency and carries the issued tag. Nothing issues without a previously accepted request. The number of held requests never exceeds the total capacity. The busy counter only holds or steps by one.

Other behaviours depend on the exact cycle of each event, so only the bench's scenarios can show them:
- In-order issue per kind.
- The one-cycle texture delay caused by head-of-line blocking in the shared queue, against the immediate texture start in the split organisation.
- Back-pressure that depends on the kind.
- Back-to-back reuse of a unit in its completion cycle.
- The exact busy-cycle totals.

// File: rtl/fsd_pkg.sv
package fsd_pkg;

  typedef enum logic {
    KIND_VTX = 1'b0,
    KIND_TEX = 1'b1
  } fetchKind_t;

  // Strobes from control to datapath, one cycle wide.
  typedef struct packed {
    logic push;      // accept the presented request
    logic popA;      // retire slot A
    logic popB;      // retire slot B
    logic issueVtx;  // start the vertex unit
    logic issueTex;  // start the texture unit
    logic vtxFromB;  // vertex issue takes slot B
    logic texFromB;  // texture issue takes slot B
  } fsdStrobe_t;

endpackage

// File: rtl/fsd_queue.sv
// Circular buffer that exposes its two oldest entries and retires up to
// two per cycle. DEPTH must be a power of two.
module fsd_queue #(
  parameter int DEPTH = 2,
  parameter int W     = 9,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          pushEn,
  input  logic [W-1:0]  pushData,
  input  logic [1:0]    popCnt,
  output logic [W-1:0]  head,
  output logic [W-1:0]  second,
  output logic [CW-1:0] count,
  output logic          full
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wrPtr;
  logic [PW-1:0] rdPtr;

  always_ff @(posedge clk) begin
    if (pushEn) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushEn) wrPtr <= wrPtr + PW'(1);
      rdPtr <= rdPtr + PW'(popCnt);
      count <= count + CW'(pushEn) - CW'(popCnt);
    end
  end

  assign head   = mem[rdPtr];
  assign second = mem[rdPtr + PW'(1)];
  assign full   = (count == CW'(DEPTH));

endmodule

// File: rtl/fsd_unit_timer.sv
// Non-pipelined fetch unit model: a countdown loaded with LAT on issue.
module fsd_unit_timer #(
  parameter int LAT   = 1,
  parameter int TAG_W = 8,
  localparam int LW   = $clog2(LAT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             issue,
  input  logic [TAG_W-1:0] issueTag,
  output logic             free,
  output logic             busy,
  output logic             done,
  output logic [TAG_W-1:0] doneTag
);

  logic [LW-1:0]    remain;
  logic [TAG_W-1:0] heldTag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remain  <= '0;
      heldTag <= '0;
    end else if (issue) begin
      remain  <= LW'(LAT);
      heldTag <= issueTag;
    end else if (remain != '0) begin
      remain <= remain - LW'(1);
    end
  end

  assign done    = (remain == LW'(1));
  assign free    = (remain <= LW'(1));
  assign busy    = (remain != '0);
  assign doneTag = heldTag;

endmodule

// File: rtl/fsd_datapath.sv
module fsd_datapath
  import fsd_pkg::*;
#(
  parameter int DEDICATED = 1,
  parameter int QDEPTH    = 2,
  parameter int VLAT      = 2,
  parameter int TLAT      = 1,
  parameter int TAG_W     = 8,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  fsdStrobe_t       strobe,
  input  logic             reqIsTex,
  input  logic [TAG_W-1:0] reqTag,
  output logic             aValid,
  output logic             aTex,
  output logic             bValid,
  output logic             bTex,
  output logic             fullVtx,
  output logic             fullTex,
  output logic             vtxFree,
  output logic             texFree,
  output logic [TAG_W-1:0] vtxIssueTag,
  output logic [TAG_W-1:0] texIssueTag,
  output logic             vtxDone,
  output logic [TAG_W-1:0] vtxDoneTag,
  output logic             texDone,
  output logic [TAG_W-1:0] texDoneTag,
  output logic [CNT_W-1:0] busyCycles
);

  localparam int EW     = TAG_W + 1;
  localparam int UDEPTH = 2 * QDEPTH;

  logic [EW-1:0]    pushEntry;
  logic [TAG_W-1:0] aTag;
  logic [TAG_W-1:0] bTag;
  logic             queuesOccupied;
  logic             vtxBusy;
  logic             texBusy;

  assign pushEntry = {reqIsTex, reqTag};

  generate
    if (DEDICATED != 0) begin : g_split
      localparam int CW = $clog2(QDEPTH + 1);
      logic [EW-1:0] vHead, vSecond, tHead, tSecond;
      logic [CW-1:0] vCount, tCount;
      logic          vFull, tFull;
      logic          unusedSecond;

      fsd_queue #(.DEPTH(QDEPTH), .W(EW)) u_vtxQ (
        .clk(clk), .rstN(rstN),
        .pushEn(strobe.push & (reqIsTex == KIND_VTX)),
        .pushData(pushEntry),
        .popCnt({1'b0, strobe.popA}),
        .head(vHead), .second(vSecond), .count(vCount), .full(vFull)
      );

      fsd_queue #(.DEPTH(QDEPTH), .W(EW)) u_texQ (
        .clk(clk), .rstN(rstN),
        .pushEn(strobe.push & (reqIsTex == KIND_TEX)),
        .pushData(pushEntry),
        .popCnt({1'b0, strobe.popB}),
        .head(tHead), .second(tSecond), .count(tCount), .full(tFull)
      );

      assign aValid         = (vCount != '0);
      assign aTex           = vHead[EW-1];
      assign aTag           = vHead[TAG_W-1:0];
      assign bValid         = (tCount != '0);
      assign bTex           = tHead[EW-1];
      assign bTag           = tHead[TAG_W-1:0];
      assign fullVtx        = vFull;
      assign fullTex        = tFull;
      assign queuesOccupied = aValid | bValid;
      assign unusedSecond   = ^{vSecond, tSecond};
    end else begin : g_unified
      localparam int CW = $clog2(UDEPTH + 1);
      logic [EW-1:0] uHead, uSecond;
      logic [CW-1:0] uCount;
      logic          uFull;

      fsd_queue #(.DEPTH(UDEPTH), .W(EW)) u_sharedQ (
        .clk(clk), .rstN(rstN),
        .pushEn(strobe.push),
        .pushData(pushEntry),
        .popCnt(2'(strobe.popA) + 2'(strobe.popB)),
        .head(uHead), .second(uSecond), .count(uCount), .full(uFull)
      );

      assign aValid         = (uCount >= CW'(1));
      assign aTex           = uHead[EW-1];
      assign aTag           = uHead[TAG_W-1:0];
      assign bValid         = (uCount >= CW'(2));
      assign bTex           = uSecond[EW-1];
      assign bTag           = uSecond[TAG_W-1:0];
      assign fullVtx        = uFull;
      assign fullTex        = uFull;
      assign queuesOccupied = aValid;
    end
  endgenerate

  assign vtxIssueTag = strobe.vtxFromB ? bTag : aTag;
  assign texIssueTag = strobe.texFromB ? bTag : aTag;

  fsd_unit_timer #(.LAT(VLAT), .TAG_W(TAG_W)) u_vtxUnit (
    .clk(clk), .rstN(rstN),
    .issue(strobe.issueVtx), .issueTag(vtxIssueTag),
    .free(vtxFree), .busy(vtxBusy), .done(vtxDone), .doneTag(vtxDoneTag)
  );

  fsd_unit_timer #(.LAT(TLAT), .TAG_W(TAG_W)) u_texUnit (
    .clk(clk), .rstN(rstN),
    .issue(strobe.issueTex), .issueTag(texIssueTag),
    .free(texFree), .busy(texBusy), .done(texDone), .doneTag(texDoneTag)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyCycles <= '0;
    end else if ((queuesOccupied | vtxBusy | texBusy) && (busyCycles != '1)) begin
      busyCycles <= busyCycles + CNT_W'(1);
    end
  end

endmodule

// File: rtl/fsd_control.sv
module fsd_control
  import fsd_pkg::*;
#(
  parameter int DEDICATED = 1
) (
  input  logic       reqValid,
  input  logic       reqIsTex,
  input  logic       fullVtx,
  input  logic       fullTex,
  input  logic       aValid,
  input  logic       aTex,
  input  logic       bValid,
  input  logic       bTex,
  input  logic       vtxFree,
  input  logic       texFree,
  output logic       reqReady,
  output fsdStrobe_t strobe
);

  logic aGo;
  logic bGo;

  assign reqReady = (reqIsTex == KIND_TEX) ? !fullTex : !fullVtx;

  generate
    if (DEDICATED != 0) begin : g_split
      // Slot A is the vertex queue head, slot B the texture queue head.
      assign aGo = aValid & (aTex == KIND_VTX) & vtxFree;
      assign bGo = bValid & (bTex == KIND_TEX) & texFree;
      always_comb begin
        strobe          = '0;
        strobe.push     = reqValid & reqReady;
        strobe.popA     = aGo;
        strobe.popB     = bGo;
        strobe.issueVtx = aGo;
        strobe.issueTex = bGo;
        strobe.vtxFromB = 1'b0;
        strobe.texFromB = 1'b1;
      end
    end else begin : g_unified
      // Slot A is the oldest entry, slot B the one behind it.
      assign aGo = aValid & ((aTex == KIND_TEX) ? texFree : vtxFree);
      assign bGo = aGo & bValid & (bTex != aTex) &
                   ((bTex == KIND_TEX) ? texFree : vtxFree);
      always_comb begin
        strobe          = '0;
        strobe.push     = reqValid & reqReady;
        strobe.popA     = aGo;
        strobe.popB     = bGo;
        strobe.issueVtx = (aGo & (aTex == KIND_VTX)) | (bGo & (bTex == KIND_VTX));
        strobe.issueTex = (aGo & (aTex == KIND_TEX)) | (bGo & (bTex == KIND_TEX));
        strobe.vtxFromB = bGo & (bTex == KIND_VTX);
        strobe.texFromB = bGo & (bTex == KIND_TEX);
      end
    end
  endgenerate

endmodule

// File: rtl/fetch_split_dispatch.sv
module fetch_split_dispatch
  import fsd_pkg::*;
#(
  parameter int DEDICATED = 1,
  parameter int QDEPTH    = 2,
  parameter int VLAT      = 2,
  parameter int TLAT      = 1,
  parameter int TAG_W     = 8,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqIsTex,
  input  logic [TAG_W-1:0] reqTag,
  output logic             reqReady,
  output logic             vtxIssue,
  output logic [TAG_W-1:0] vtxIssueTag,
  output logic             texIssue,
  output logic [TAG_W-1:0] texIssueTag,
  output logic             vtxDone,
  output logic [TAG_W-1:0] vtxDoneTag,
  output logic             texDone,
  output logic [TAG_W-1:0] texDoneTag,
  output logic [CNT_W-1:0] busyCycles
);

  fsdStrobe_t strobe;
  logic aValid, aTex, bValid, bTex;
  logic fullVtx, fullTex, vtxFree, texFree;

  fsd_control #(.DEDICATED(DEDICATED)) u_ctrl (
    .reqValid(reqValid), .reqIsTex(reqIsTex),
    .fullVtx(fullVtx), .fullTex(fullTex),
    .aValid(aValid), .aTex(aTex), .bValid(bValid), .bTex(bTex),
    .vtxFree(vtxFree), .texFree(texFree),
    .reqReady(reqReady), .strobe(strobe)
  );

  fsd_datapath #(
    .DEDICATED(DEDICATED), .QDEPTH(QDEPTH), .VLAT(VLAT), .TLAT(TLAT),
    .TAG_W(TAG_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqIsTex(reqIsTex), .reqTag(reqTag),
    .aValid(aValid), .aTex(aTex), .bValid(bValid), .bTex(bTex),
    .fullVtx(fullVtx), .fullTex(fullTex),
    .vtxFree(vtxFree), .texFree(texFree),
    .vtxIssueTag(vtxIssueTag), .texIssueTag(texIssueTag),
    .vtxDone(vtxDone), .vtxDoneTag(vtxDoneTag),
    .texDone(texDone), .texDoneTag(texDoneTag),
    .busyCycles(busyCycles)
  );

  assign vtxIssue = strobe.issueVtx;
  assign texIssue = strobe.issueTex;

endmodule

// File: rtl/fsd_dispatch_chk.sv
module fsd_dispatch_chk #(
  parameter int QDEPTH = 2,
  parameter int VLAT   = 2,
  parameter int TLAT   = 1,
  parameter int TAG_W  = 8,
  parameter int CNT_W  = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic             vtxIssue,
  input logic [TAG_W-1:0] vtxIssueTag,
  input logic             texIssue,
  input logic [TAG_W-1:0] texIssueTag,
  input logic             vtxDone,
  input logic [TAG_W-1:0] vtxDoneTag,
  input logic             texDone,
  input logic [TAG_W-1:0] texDoneTag,
  input logic [CNT_W-1:0] busyCycles
);

  logic [7:0]       held;
  logic             vOut, tOut;
  logic [7:0]       vAge, tAge;
  logic [TAG_W-1:0] vTag, tTag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      held <= '0;
      vOut <= 1'b0;
      tOut <= 1'b0;
      vAge <= '0;
      tAge <= '0;
      vTag <= '0;
      tTag <= '0;
    end else begin
      held <= held + 8'(reqValid & reqReady) - 8'(vtxIssue) - 8'(texIssue);
      if (vtxIssue) begin
        vOut <= 1'b1; vAge <= 8'd1; vTag <= vtxIssueTag;
      end else if (vtxDone) begin
        vOut <= 1'b0;
      end else if (vOut && vAge != 8'hFF) begin
        vAge <= vAge + 8'd1;
      end
      if (texIssue) begin
        tOut <= 1'b1; tAge <= 8'd1; tTag <= texIssueTag;
      end else if (texDone) begin
        tOut <= 1'b0;
      end else if (tOut && tAge != 8'hFF) begin
        tAge <= tAge + 8'd1;
      end
    end
  end

  // R2
  vtx_needs_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    vtxIssue |-> held != 8'd0);

  // R2
  tex_needs_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    texIssue |-> held != 8'd0);

  // R3
  held_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    held <= 8'(2 * QDEPTH));

  // R6
  dual_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vtxIssue && texIssue) |-> held >= 8'd2);

  // R8
  vtx_single_flight_chk: assert property (@(posedge clk) disable iff (!rstN)
    vtxIssue |-> (!vOut || vtxDone));

  // R8
  tex_single_flight_chk: assert property (@(posedge clk) disable iff (!rstN)
    texIssue |-> (!tOut || texDone));

  // R9
  vtx_done_timing_chk: assert property (@(posedge clk) disable iff (!rstN)
    vtxDone |-> (vOut && vAge == 8'(VLAT) && vtxDoneTag == vTag));

  // R9
  tex_done_timing_chk: assert property (@(posedge clk) disable iff (!rstN)
    texDone |-> (tOut && tAge == 8'(TLAT) && texDoneTag == tTag));

  // R10
  busy_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyCycles == $past(busyCycles)) || (busyCycles == $past(busyCycles) + CNT_W'(1)));

endmodule

bind fetch_split_dispatch fsd_dispatch_chk #(
  .QDEPTH(QDEPTH), .VLAT(VLAT), .TLAT(TLAT), .TAG_W(TAG_W), .CNT_W(CNT_W)
) u_dispatchChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .vtxIssue(vtxIssue), .vtxIssueTag(vtxIssueTag),
  .texIssue(texIssue), .texIssueTag(texIssueTag),
  .vtxDone(vtxDone), .vtxDoneTag(vtxDoneTag),
  .texDone(texDone), .texDoneTag(texDoneTag),
  .busyCycles(busyCycles)
);

// File: tb/sim_fetch_split_dispatch.sv
module sim_fetch_split_dispatch;

  localparam int QD = 2;
  localparam int VL = 2;
  localparam int TL = 1;
  localparam int TW = 8;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // index 0: split organisation (u0), index 1: shared organisation (u1)
  logic          vld [2];
  logic          isT [2];
  logic [TW-1:0] tg  [2];
  logic          rdy [2];
  logic          vI  [2];
  logic          tI  [2];
  logic          vD  [2];
  logic          tD  [2];
  logic [TW-1:0] vIT [2];
  logic [TW-1:0] tIT [2];
  logic [TW-1:0] vDT [2];
  logic [TW-1:0] tDT [2];
  logic [CW-1:0] bc  [2];

  fetch_split_dispatch #(.DEDICATED(1), .QDEPTH(QD), .VLAT(VL), .TLAT(TL),
                         .TAG_W(TW), .CNT_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(vld[0]), .reqIsTex(isT[0]), .reqTag(tg[0]),
    .reqReady(rdy[0]), .vtxIssue(vI[0]), .vtxIssueTag(vIT[0]),
    .texIssue(tI[0]), .texIssueTag(tIT[0]), .vtxDone(vD[0]), .vtxDoneTag(vDT[0]),
    .texDone(tD[0]), .texDoneTag(tDT[0]), .busyCycles(bc[0]));

  fetch_split_dispatch #(.DEDICATED(0), .QDEPTH(QD), .VLAT(VL), .TLAT(TL),
                         .TAG_W(TW), .CNT_W(CW)) u1 (
    .clk(clk), .rstN(rstN), .reqValid(vld[1]), .reqIsTex(isT[1]), .reqTag(tg[1]),
    .reqReady(rdy[1]), .vtxIssue(vI[1]), .vtxIssueTag(vIT[1]),
    .texIssue(tI[1]), .texIssueTag(tIT[1]), .vtxDone(vD[1]), .vtxDoneTag(vDT[1]),
    .texDone(tD[1]), .texDoneTag(tDT[1]), .busyCycles(bc[1]));

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  // expected issue order per instance and kind (scoreboard)
  int expV0[$];
  int expT0[$];
  int expV1[$];
  int expT1[$];

  int issCyc [2][256];
  int accCyc [2][256];
  bit outV [2];
  bit outT [2];
  int lastVCyc [2];
  int lastTCyc [2];
  int lastVTag [2];
  int lastTTag [2];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic pushExp(input int i, input bit kind, input int tag);
    case ({i[0], kind})
      2'b00: expV0.push_back(tag);
      2'b01: expT0.push_back(tag);
      2'b10: expV1.push_back(tag);
      default: expT1.push_back(tag);
    endcase
  endtask

  function automatic int popExp(input int i, input bit kind);
    int r;
    r = -1;
    case ({i[0], kind})
      2'b00: if (expV0.size() > 0) r = expV0.pop_front();
      2'b01: if (expT0.size() > 0) r = expT0.pop_front();
      2'b10: if (expV1.size() > 0) r = expV1.pop_front();
      default: if (expT1.size() > 0) r = expT1.pop_front();
    endcase
    return r;
  endfunction

  // monitor: pops the scoreboard on every issue, times every completion
  task automatic monUnit(input int i);
    int e;
    if (vD[i]) begin
      chk(outV[i], "R9 vertex done without fetch", 0, 1);
      chk(int'(vDT[i]) == lastVTag[i], "R9 vertex done tag", int'(vDT[i]), lastVTag[i]);
      chk(cyc - lastVCyc[i] == VL, "R9 vertex latency", cyc - lastVCyc[i], VL);
      outV[i] = 1'b0;
    end
    if (tD[i]) begin
      chk(outT[i], "R9 texture done without fetch", 0, 1);
      chk(int'(tDT[i]) == lastTTag[i], "R9 texture done tag", int'(tDT[i]), lastTTag[i]);
      chk(cyc - lastTCyc[i] == TL, "R9 texture latency", cyc - lastTCyc[i], TL);
      outT[i] = 1'b0;
    end
    if (vI[i]) begin
      chk(!outV[i], "R8 vertex unit reissued while busy", 1, 0);
      e = popExp(i, 1'b0);
      chk(e == int'(vIT[i]), "R5 vertex issue order", int'(vIT[i]), e);
      outV[i] = 1'b1;
      lastVCyc[i] = cyc;
      lastVTag[i] = int'(vIT[i]);
      issCyc[i][vIT[i]] = cyc;
    end
    if (tI[i]) begin
      chk(!outT[i], "R8 texture unit reissued while busy", 1, 0);
      e = popExp(i, 1'b1);
      chk(e == int'(tIT[i]), "R5 texture issue order", int'(tIT[i]), e);
      outT[i] = 1'b1;
      lastTCyc[i] = cyc;
      lastTTag[i] = int'(tIT[i]);
      issCyc[i][tIT[i]] = cyc;
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      for (int i = 0; i < 2; i++) monUnit(i);
    end
  end

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    for (int i = 0; i < 2; i++) begin
      vld[i] = 1'b0; isT[i] = 1'b0; tg[i] = '0;
      outV[i] = 1'b0; outT[i] = 1'b0;
      for (int k = 0; k < 256; k++) begin issCyc[i][k] = -1; accCyc[i][k] = -1; end
    end
    expV0.delete(); expT0.delete(); expV1.delete(); expT1.delete();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // drive at the falling edge, hold until taken at a rising edge
  task automatic pushReq(input int i, input bit kind, input int tag);
    @(negedge clk);
    vld[i] = 1'b1;
    isT[i] = kind;
    tg[i]  = TW'(tag);
    #1;
    while (!rdy[i]) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    accCyc[i][tag] = cyc;
    pushExp(i, kind, tag);
  endtask

  task automatic idle(input int i, input int n);
    @(negedge clk);
    vld[i] = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    doReset();
    // R1: state straight after reset
    #1;
    for (int i = 0; i < 2; i++) begin
      chk(rdy[i] == 1'b1, "R1 ready for vertex after reset", int'(rdy[i]), 1);
      isT[i] = 1'b1;
      #1;
      chk(rdy[i] == 1'b1, "R1 ready for texture after reset", int'(rdy[i]), 1);
      chk({vI[i], tI[i], vD[i], tD[i]} == 4'b0, "R1 no pulses after reset",
          int'({vI[i], tI[i], vD[i], tD[i]}), 0);
      chk(bc[i] == '0, "R1 busy counter cleared", int'(bc[i]), 0);
    end

    // R2 / R10: lone vertex fetch on an idle block
    doReset();
    pushReq(0, 1'b0, 1);
    idle(0, 6);
    chk(issCyc[0][1] == accCyc[0][1], "R2 issue in cycle after acceptance",
        issCyc[0][1] - accCyc[0][1], 0);
    chk(int'(bc[0]) == 1 + VL, "R10 busy cycles for one vertex fetch", int'(bc[0]), 1 + VL);

    // R6 / R7 / R10: vertex, vertex, vertex, texture in both organisations
    for (int i = 0; i < 2; i++) begin
      doReset();
      pushReq(i, 1'b0, 1);
      pushReq(i, 1'b0, 2);
      pushReq(i, 1'b0, 3);
      pushReq(i, 1'b1, 4);
      idle(i, 10);
      chk(issCyc[i][3] - accCyc[i][1] == 4, "R7 third vertex start cycle",
          issCyc[i][3] - accCyc[i][1], 4);
      chk(int'(bc[i]) == 7, "R10 busy cycles for mixed burst", int'(bc[i]), 7);
      if (i == 0) begin
        chk(issCyc[0][4] == accCyc[0][4], "R6 split texture starts at once",
            issCyc[0][4] - accCyc[0][4], 0);
      end else begin
        chk(issCyc[1][4] - accCyc[1][4] == 1, "R7 shared texture blocked by head",
            issCyc[1][4] - accCyc[1][4], 1);
        chk(issCyc[1][4] == issCyc[1][3], "R6 vertex and texture start together",
            issCyc[1][4], issCyc[1][3]);
      end
    end

    // R3: split queue full for vertex only
    doReset();
    pushReq(0, 1'b0, 1);
    pushReq(0, 1'b0, 2);
    pushReq(0, 1'b0, 3);
    @(negedge clk);
    vld[0] = 1'b0;
    isT[0] = 1'b0;
    #1;
    chk(rdy[0] == 1'b0, "R3 vertex ready low when vertex queue full", int'(rdy[0]), 0);
    isT[0] = 1'b1;
    #1;
    chk(rdy[0] == 1'b1, "R3 texture ready unaffected by vertex queue", int'(rdy[0]), 1);
    repeat (12) @(negedge clk);
    chk(expV0.size() == 0, "R5 all split vertex requests issued", expV0.size(), 0);

    // R4: shared queue full blocks both kinds
    doReset();
    for (int k = 1; k <= 7; k++) pushReq(1, 1'b0, k);
    @(negedge clk);
    vld[1] = 1'b0;
    isT[1] = 1'b1;
    #1;
    chk(rdy[1] == 1'b0, "R4 texture ready low when shared queue full", int'(rdy[1]), 0);
    isT[1] = 1'b0;
    #1;
    chk(rdy[1] == 1'b0, "R4 vertex ready low when shared queue full", int'(rdy[1]), 0);
    repeat (30) @(negedge clk);
    chk(expV1.size() == 0, "R5 all shared vertex requests issued", expV1.size(), 0);

    // R8: texture unit reused in its completion cycle
    doReset();
    pushReq(0, 1'b1, 1);
    pushReq(0, 1'b1, 2);
    idle(0, 5);
    chk(issCyc[0][2] == accCyc[0][2], "R8 back-to-back texture start",
        issCyc[0][2] - accCyc[0][2], 0);
    chk(issCyc[0][2] - issCyc[0][1] == TL, "R8 texture restart spacing",
        issCyc[0][2] - issCyc[0][1], TL);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule